// File: doc/BRIEF.md
# Pseudo-SRAM Power-Mode Tracker

This block follows the power state of a pseudo-static RAM from its control pins. It sits inside a behavioural memory model or beside a bus monitor. It samples the chip-enable, byte-lane, output-enable and write-enable pins on a free-running clock. It counts microsecond ticks to time the start-up wait and the wake-up wait. It reports the current mode and whether the part is usable. It also shows whether array contents have survived and which access the pins request.

The states are INIT, ACTIVE, STANDBY, DPD and WAKE.
- INIT is the start-up wait after reset.
- ACTIVE and STANDBY are the two usable states.
- DPD is deep power-down.
- WAKE is the wait after leaving deep power-down.

The transitions are:
- **wait_done**: INIT or WAKE moves to ACTIVE or STANDBY once the wait counter is exhausted.
- **select**: the pins move the block between STANDBY and ACTIVE.
- **sleep**: the second chip enable going low moves the block from any state other than DPD into DPD.
- **wake**: the second chip enable going high moves DPD into WAKE.

Any read or write attempted during INIT or WAKE is latched as a protocol violation.

Top module: `psram_pwr_fsm`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mode is INIT (code 0), ready is 0, array_intact is 1, violation is 0 and op is deselect (code 0).
- R2: INIT stays in place until WAIT_US microsecond ticks (default 200) have been counted. On the next clock after the last tick it enters ACTIVE or STANDBY, chosen by the pins.
- R3: In a usable state the block takes STANDBY (code 2) one clock after the pins show ce2 high with either ce1_n high or both lb_n and ub_n high.
- R4: In a usable state the block takes ACTIVE (code 1) one clock after the pins show ce1_n low, ce2 high and at least one of lb_n and ub_n low.
- R5: ce2 low in INIT, ACTIVE, STANDBY or WAKE gives DPD (code 3) on the next clock.
- R6: ce2 high in DPD gives WAKE (code 4) on the next clock. WAKE needs WAIT_US fresh ticks before it becomes usable. A return to DPD during WAKE restarts the count.
- R7: ready is 1 only in ACTIVE and STANDBY.
- R8: array_intact clears on entry to DPD and stays clear until reset. STANDBY leaves it set.
- R9: violation becomes 1 on the clock after a read or write code is decoded while in INIT or WAKE. It stays 1 until reset.
- R10: op is the pin decode registered once per clock. The codes are: deselect 0 (ce1_n high, ce2 low, or both lanes high), output disabled 1 (oe_n and we_n high), read low lane 2, read high lane 3, read word 4, write low lane 5, write high lane 6, write word 7.
- R11: we_n low selects a write code whatever the level of oe_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset, stands for power-on |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Second chip enable; low requests deep power-down |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Low byte lane enable, active low |
| ub_n | input | 1 | High byte lane enable, active low |
| mode | output | 3 | Current state code |
| ready | output | 1 | Part usable |
| array_intact | output | 1 | Contents not lost to deep power-down |
| violation | output | 1 | Sticky access-during-wait flag |
| op | output | 4 | Registered access decode |

## Verification
The wake wait can end in the same cycle that a read is present on the pins. The bench therefore holds a read across the last tick of WAKE and expects two results: violation set, and the block landing in ACTIVE rather than staying in WAKE. A second coincidence is ce2 falling partway through WAKE. The bench drops ce2 after half the ticks and checks that the later exit needs a full fresh count: still WAKE one tick short, usable one clock after the final tick.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        MODE_INIT    = 3'd0,
        MODE_ACTIVE  = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_DPD     = 3'd3,
        MODE_WAKE    = 3'd4
    } pmode_e;

    typedef enum logic [3:0] {
        OP_DESEL   = 4'd0,
        OP_OUTOFF  = 4'd1,
        OP_RD_LO   = 4'd2,
        OP_RD_HI   = 4'd3,
        OP_RD_WORD = 4'd4,
        OP_WR_LO   = 4'd5,
        OP_WR_HI   = 4'd6,
        OP_WR_WORD = 4'd7
    } op_e;

    function automatic logic op_is_access(op_e o);
        return (o != OP_DESEL) && (o != OP_OUTOFF);
    endfunction

endpackage

// File: rtl/psram_op_decode.sv
module psram_op_decode
    import psram_pwr_pkg::*;
(
    input  logic ce1_n,
    input  logic ce2,
    input  logic oe_n,
    input  logic we_n,
    input  logic lb_n,
    input  logic ub_n,
    output op_e  op_comb,
    output logic selected
);
    logic [1:0] lanes;

    always_comb begin
        lanes    = {~ub_n, ~lb_n};
        selected = ~ce1_n & ce2 & (|lanes);
        op_comb  = OP_DESEL;
        if (selected) begin
            if (!we_n) begin
                unique case (lanes)
                    2'b01:   op_comb = OP_WR_LO;
                    2'b10:   op_comb = OP_WR_HI;
                    default: op_comb = OP_WR_WORD;
                endcase
            end else if (!oe_n) begin
                unique case (lanes)
                    2'b01:   op_comb = OP_RD_LO;
                    2'b10:   op_comb = OP_RD_HI;
                    default: op_comb = OP_RD_WORD;
                endcase
            end else begin
                op_comb = OP_OUTOFF;
            end
        end
    end
endmodule

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
    parameter int WAIT_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(WAIT_US + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_US);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LOAD_VAL;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/psram_status_flags.sv
module psram_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_dpd,
    input  logic bad_access,
    output logic intact,
    output logic viol
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intact <= 1'b1;
            viol   <= 1'b0;
        end else begin
            if (enter_dpd)  intact <= 1'b0;
            if (bad_access) viol   <= 1'b1;
        end
    end
endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
    import psram_pwr_pkg::*;
#(
    parameter int WAIT_US = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       ce1_n,
    input  logic       ce2,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       lb_n,
    input  logic       ub_n,
    output logic [2:0] mode,
    output logic       ready,
    output logic       array_intact,
    output logic       violation,
    output logic [3:0] op
);
    pmode_e state_q, state_d;
    op_e    op_comb, op_q;
    logic   selected, wait_done, in_wait, enter_dpd, bad_access;
    pmode_e usable_pick;

    psram_op_decode u_dec (
        .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
        .lb_n(lb_n), .ub_n(ub_n), .op_comb(op_comb), .selected(selected)
    );

    psram_wait_timer #(.WAIT_US(WAIT_US)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(state_q == MODE_DPD),
        .run(in_wait), .tick(us_tick), .done(wait_done)
    );

    psram_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .enter_dpd(enter_dpd),
        .bad_access(bad_access), .intact(array_intact), .viol(violation)
    );

    assign usable_pick = selected ? MODE_ACTIVE : MODE_STANDBY;
    assign in_wait     = (state_q == MODE_INIT) || (state_q == MODE_WAKE);
    assign enter_dpd   = (state_d == MODE_DPD) && (state_q != MODE_DPD);
    assign bad_access  = in_wait && op_is_access(op_comb);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_INIT, MODE_WAKE: begin
                if (!ce2)           state_d = MODE_DPD;
                else if (wait_done) state_d = usable_pick;
            end
            MODE_ACTIVE, MODE_STANDBY: begin
                if (!ce2) state_d = MODE_DPD;
                else      state_d = usable_pick;
            end
            MODE_DPD: begin
                if (ce2) state_d = MODE_WAKE;
            end
            default: state_d = MODE_INIT;
        endcase
    end

    // state and op registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_INIT;
            op_q    <= OP_DESEL;
        end else begin
            state_q <= state_d;
            op_q    <= op_comb;
        end
    end

    // outputs
    always_comb begin
        mode  = state_q;
        op    = op_q;
        ready = (state_q == MODE_ACTIVE) || (state_q == MODE_STANDBY);
    end
endmodule

// File: rtl/psram_pwr_fsm_chk.sv
module psram_pwr_fsm_chk
    import psram_pwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce1_n,
    input logic       ce2,
    input logic [2:0] mode,
    input logic       ready,
    input logic       array_intact,
    input logic       violation,
    input logic [3:0] op
);
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce2 && mode != MODE_DPD) |=> (mode == MODE_DPD)); // R5
    AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DPD && ce2) |=> (mode == MODE_WAKE)); // R6
    AST_ACTIVE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == MODE_ACTIVE) |-> ($past(!ce1_n) && $past(ce2))); // R4
    AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INIT || mode == MODE_WAKE || mode == MODE_DPD) |-> !ready); // R7
    AST_DPD_LOSES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DPD) |-> !array_intact); // R8
    AST_INTACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !array_intact |=> !array_intact); // R8
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation); // R9
    AST_DESEL_OP: assert property (@(posedge clk) disable iff (!rst_n)
        ce1_n |=> (op == OP_DESEL)); // R10
endmodule

bind psram_pwr_fsm psram_pwr_fsm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .mode(mode),
    .ready(ready), .array_intact(array_intact), .violation(violation), .op(op)
);

// File: tb/psram_pwr_fsm_tb_top.sv
`timescale 1ns/1ps
module psram_pwr_fsm_tb_top;
    localparam int WAIT_US = 200;

    logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0;
    logic ce1_n = 1'b1, ce2 = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [2:0] mode;
    logic ready, array_intact, violation;
    logic [3:0] op;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    psram_pwr_fsm #(.WAIT_US(WAIT_US)) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ce1_n(ce1_n), .ce2(ce2),
        .oe_n(oe_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .mode(mode),
        .ready(ready), .array_intact(array_intact), .violation(violation), .op(op)
    );

    // pins {ce1_n,ce2,oe_n,we_n,lb_n,ub_n}, op, mode
    localparam logic [12:0] VEC [10] = '{
        {6'b110100, 4'd0, 3'd2},  // R3 deselect via ce1_n
        {6'b011111, 4'd0, 3'd2},  // R3 both lanes off
        {6'b011100, 4'd1, 3'd1},  // R4 output disabled
        {6'b010101, 4'd2, 3'd1},  // R10 read low
        {6'b010110, 4'd3, 3'd1},  // R10 read high
        {6'b010100, 4'd4, 3'd1},  // R10 read word
        {6'b011001, 4'd5, 3'd1},  // R10 write low
        {6'b011010, 4'd6, 3'd1},  // R10 write high
        {6'b010000, 4'd7, 3'd1},  // R11 write with oe_n low
        {6'b111111, 4'd0, 3'd2}   // R3 back to standby
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_pins(logic [5:0] p);
        @(negedge clk);
        {ce1_n, ce2, oe_n, we_n, lb_n, ub_n} = p;
    endtask

    task automatic give_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mode", mode, 0);
        check("R1 ready", ready, 0);
        check("R1 intact", array_intact, 1);
        check("R1 viol", violation, 0);
        check("R1 op", op, 0);
        rst_n = 1'b1;
        step();
        check("R1 mode after release", mode, 0);

        // R2 start-up wait
        give_ticks(WAIT_US - 1);
        step();
        check("R2 still INIT", mode, 0);
        check("R7 not ready in INIT", ready, 0);
        give_ticks(1);
        step();
        check("R2 usable STANDBY", mode, 2);
        check("R7 ready in STANDBY", ready, 1);

        // vector table
        for (int k = 0; k < 10; k++) begin
            set_pins(VEC[k][12:7]);
            step();
            check("R10 op vector", op, VEC[k][6:3]);
            check("R3/R4 mode vector", mode, VEC[k][2:0]);
        end
        check("R8 standby keeps intact", array_intact, 1);
        check("R9 no violation when usable", violation, 0);

        // R5 sleep from ACTIVE
        set_pins(6'b011100);
        step();
        check("R4 active", mode, 1);
        set_pins(6'b001100);
        step();
        check("R5 DPD", mode, 3);
        check("R8 intact cleared", array_intact, 0);
        check("R7 not ready in DPD", ready, 0);

        // R6 wake with restart
        set_pins(6'b111111);
        step();
        check("R6 WAKE", mode, 4);
        give_ticks(WAIT_US / 2);
        set_pins(6'b101111);
        step();
        check("R5 DPD from WAKE", mode, 3);
        set_pins(6'b111111);
        step();
        check("R6 WAKE again", mode, 4);
        give_ticks(WAIT_US - 1);
        step();
        check("R6 restart still WAKE", mode, 4);
        check("R9 clean before access", violation, 0);
        set_pins(6'b010100);  // read word during wait
        give_ticks(1);
        step();
        check("R9 violation", violation, 1);
        check("R6 usable after wake", mode, 1);
        check("R8 stays cleared", array_intact, 0);

        // second reset, then sleep straight from INIT
        set_pins(6'b111111);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check("R1 intact restored", array_intact, 1);
        check("R1 viol cleared", violation, 0);
        set_pins(6'b101111);
        step();
        check("R5 DPD from INIT", mode, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule